// File: doc/BRIEF.md
# Queued Event Supervisor with Transition Trace

This block takes event requests from surrounding logic, stamps each one with the value of a free-running cycle counter and with the requester's source number, and stores it in a small first-in first-out queue. Storing the event takes one cycle and never waits on the policy logic. A supervisor state machine takes the oldest queued event, applies a fixed four-state transition table to it, and produces one trace record per event. The record holds the capture time, the source, the state before, the event, the state after, an action code and an error code.

An event that has no transition in the current state leaves the state unchanged. Its record raises an unexpected-event flag, so no event is lost without a trace. While waiting in the armed state, timeouts first use up a retry budget. Only when the budget is gone does a timeout move the machine on to its fallback state. Records leave on a valid/ready stream, and the state machine stalls while a record waits to be accepted. A trace-enable input suppresses records without changing how the state machine behaves.

Top module: `sup_supervisor`

## Requirements
- R1: While reset is asserted, and just after it is released, state_o is IDLE (code 0), trace_valid_o is 0 and overflow_o is 0.
- R2: In IDLE (0), event EDGE (code 0) moves to ARMED (1) with action ARM (1) and error 0. TIMEOUT (1), CRC_FAIL (2) and RESET (3) keep IDLE with action HOLD (0), error 1 and trace_unexp_o set.
- R3: In ARMED (1), CRC_FAIL moves to FAULT (3) with action TRIP (4) and error 2. EDGE and RESET keep ARMED as unexpected events (action 0, error 1, flag set).
- R4: With RETRY_MAX = 2, the first two TIMEOUTs after each entry into ARMED keep ARMED with action RETRY (2). The next TIMEOUT moves to ACTIVE (2) with action GO (3). Each entry into ARMED refills the budget.
- R5: In ACTIVE (2) and in FAULT (3), RESET moves to IDLE with action CLEAR (5). Every other event holds the state as an unexpected event (action 0, error 1, flag set).
- R6: Events are processed strictly in arrival order. Each record carries the source ID given with its event and a timestamp equal to the number of clock edges between reset release and the edge that captured the event.
- R7: When the queue is empty and the output is free, an event sampled at edge N changes state_o and raises trace_valid_o after edge N+1, and not before.
- R8: While trace_valid_o is high and trace_ready_i is low, the record and state_o stay unchanged and no further event is processed.
- R9: The queue holds 8 events. An event presented while the queue is full is discarded and never processed, and overflow_o sets and stays set until reset.
- R10: With trace_en_i low, events still change state_o but no record is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Event request strobe, one event per high cycle |
| ev_code_i | input | 2 | Event code: 0 EDGE, 1 TIMEOUT, 2 CRC_FAIL, 3 RESET |
| ev_src_i | input | SRC_W (4) | Source number of the requester |
| trace_en_i | input | 1 | When high, each processed event emits a record |
| trace_ready_i | input | 1 | Consumer accepts the current record |
| trace_valid_o | output | 1 | A record is presented |
| trace_ts_o | output | TS_W (16) | Capture timestamp |
| trace_src_o | output | SRC_W (4) | Source number |
| trace_old_o | output | 2 | State before the event |
| trace_ev_o | output | 2 | Event code |
| trace_new_o | output | 2 | State after the event |
| trace_act_o | output | 3 | Action: 0 HOLD, 1 ARM, 2 RETRY, 3 GO, 4 TRIP, 5 CLEAR |
| trace_err_o | output | 2 | Error: 0 none, 1 unexpected, 2 CRC failure, 3 bad state |
| trace_unexp_o | output | 1 | Event had no transition in the old state |
| state_o | output | 2 | Current supervisor state |
| overflow_o | output | 1 | Sticky: an event was lost to a full queue |

## Verification
An event sampled at edge N sits in the queue after that edge and is popped at edge N+1. state_o and the record are therefore visible from the half cycle after N+1, and the bench checks at the falling edge before that point and at the falling edge after it. Each record stays on the port until the rising edge at which it is accepted. The scoreboard monitor compares records at falling edges while ready is high, so each record is compared exactly once. Expected timestamps come from the bench's own edge counter, read at the moment the driver presents the event.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_FAULT  = 2'd3
  } sup_state_e;

  typedef enum logic [1:0] {
    EVT_EDGE = 2'd0,
    EVT_TMO  = 2'd1,
    EVT_CRC  = 2'd2,
    EVT_CLR  = 2'd3
  } sup_event_e;

  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_ARM   = 3'd1,
    ACT_RETRY = 3'd2,
    ACT_GO    = 3'd3,
    ACT_TRIP  = 3'd4,
    ACT_CLEAR = 3'd5
  } sup_action_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_UNEXP = 2'd1,
    ERR_CRC   = 2'd2,
    ERR_STATE = 2'd3
  } sup_err_e;
endpackage

// File: rtl/sup_tick_counter.sv
module sup_tick_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/sup_evt_fifo.sv
module sup_evt_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  // a push into a full queue is dropped even if a pop happens that cycle
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full_o) ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sup_step.sv
module sup_step
  import sup_pkg::*;
#(
  parameter int unsigned RETRY_MAX = 2,
  parameter int unsigned RW        = $clog2(RETRY_MAX + 2)
) (
  input  logic [1:0]    st_i,
  input  sup_event_e    ev_i,
  input  logic [RW-1:0] rl_i,
  output sup_state_e    st_o,
  output logic [RW-1:0] rl_o,
  output sup_action_e   act_o,
  output sup_err_e      err_o,
  output logic          unexp_o
);
  always_comb begin
    st_o    = sup_state_e'(st_i);
    rl_o    = rl_i;
    act_o   = ACT_HOLD;
    err_o   = ERR_NONE;
    unexp_o = 1'b0;
    case (st_i)
      ST_IDLE: begin
        if (ev_i == EVT_EDGE) begin
          st_o  = ST_ARMED;
          rl_o  = RW'(RETRY_MAX);
          act_o = ACT_ARM;
        end else begin
          unexp_o = 1'b1;
        end
      end
      ST_ARMED: begin
        if (ev_i == EVT_TMO) begin
          if (rl_i != '0) begin
            rl_o  = rl_i - RW'(1);
            act_o = ACT_RETRY;
          end else begin
            st_o  = ST_ACTIVE;
            act_o = ACT_GO;
          end
        end else if (ev_i == EVT_CRC) begin
          st_o  = ST_FAULT;
          act_o = ACT_TRIP;
          err_o = ERR_CRC;
        end else begin
          unexp_o = 1'b1;
        end
      end
      ST_ACTIVE, ST_FAULT: begin
        if (ev_i == EVT_CLR) begin
          st_o  = ST_IDLE;
          act_o = ACT_CLEAR;
        end else begin
          unexp_o = 1'b1;
        end
      end
      default: begin
        st_o  = ST_FAULT;
        act_o = ACT_TRIP;
        err_o = ERR_STATE;
      end
    endcase
    if (unexp_o) err_o = ERR_UNEXP;
  end
endmodule

// File: rtl/sup_policy.sv
module sup_policy
  import sup_pkg::*;
#(
  parameter int unsigned TS_W      = 16,
  parameter int unsigned SRC_W     = 4,
  parameter int unsigned RETRY_MAX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             avail_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [1:0]       ev_i,
  input  logic             trace_en_i,
  input  logic             trace_ready_i,
  output logic             pop_o,
  output logic [1:0]       state_o,
  output logic             trace_valid_o,
  output logic [TS_W-1:0]  trace_ts_o,
  output logic [SRC_W-1:0] trace_src_o,
  output logic [1:0]       trace_old_o,
  output logic [1:0]       trace_ev_o,
  output logic [1:0]       trace_new_o,
  output logic [2:0]       trace_act_o,
  output logic [1:0]       trace_err_o,
  output logic             trace_unexp_o
);
  localparam int unsigned RW = $clog2(RETRY_MAX + 2);

  logic [1:0]    st_q;
  logic [RW-1:0] rl_q;
  sup_state_e    st_d;
  logic [RW-1:0] rl_d;
  sup_action_e   act_d;
  sup_err_e      err_d;
  logic          unexp_d;

  sup_step #(.RETRY_MAX(RETRY_MAX), .RW(RW)) u_step (
    .st_i    (st_q),
    .ev_i    (sup_event_e'(ev_i)),
    .rl_i    (rl_q),
    .st_o    (st_d),
    .rl_o    (rl_d),
    .act_o   (act_d),
    .err_o   (err_d),
    .unexp_o (unexp_d)
  );

  // stall while a record is held and not taken
  assign pop_o   = avail_i && (!trace_valid_o || trace_ready_i);
  assign state_o = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      rl_q          <= '0;
      trace_valid_o <= 1'b0;
      trace_ts_o    <= '0;
      trace_src_o   <= '0;
      trace_old_o   <= '0;
      trace_ev_o    <= '0;
      trace_new_o   <= '0;
      trace_act_o   <= '0;
      trace_err_o   <= '0;
      trace_unexp_o <= 1'b0;
    end else if (pop_o) begin
      st_q          <= st_d;
      rl_q          <= rl_d;
      trace_valid_o <= trace_en_i;
      if (trace_en_i) begin
        trace_ts_o    <= ts_i;
        trace_src_o   <= src_i;
        trace_old_o   <= st_q;
        trace_ev_o    <= ev_i;
        trace_new_o   <= st_d;
        trace_act_o   <= act_d;
        trace_err_o   <= err_d;
        trace_unexp_o <= unexp_d;
      end
    end else if (trace_ready_i) begin
      trace_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sup_supervisor.sv
module sup_supervisor #(
  parameter int unsigned TS_W      = 16,
  parameter int unsigned SRC_W     = 4,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned RETRY_MAX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_valid_i,
  input  logic [1:0]       ev_code_i,
  input  logic [SRC_W-1:0] ev_src_i,
  input  logic             trace_en_i,
  input  logic             trace_ready_i,
  output logic             trace_valid_o,
  output logic [TS_W-1:0]  trace_ts_o,
  output logic [SRC_W-1:0] trace_src_o,
  output logic [1:0]       trace_old_o,
  output logic [1:0]       trace_ev_o,
  output logic [1:0]       trace_new_o,
  output logic [2:0]       trace_act_o,
  output logic [1:0]       trace_err_o,
  output logic             trace_unexp_o,
  output logic [1:0]       state_o,
  output logic             overflow_o
);
  localparam int unsigned EW = TS_W + SRC_W + 2;

  logic [TS_W-1:0] now;
  logic [EW-1:0]   wr_ent, rd_ent;
  logic            q_empty, q_full, pop;

  sup_tick_counter #(.W(TS_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (now)
  );

  assign wr_ent = {now, ev_src_i, ev_code_i};

  sup_evt_fifo #(.DW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ev_valid_i),
    .data_i  (wr_ent),
    .pop_i   (pop),
    .data_o  (rd_ent),
    .empty_o (q_empty),
    .full_o  (q_full),
    .ovf_o   (overflow_o)
  );

  sup_policy #(.TS_W(TS_W), .SRC_W(SRC_W), .RETRY_MAX(RETRY_MAX)) u_pol (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .avail_i       (!q_empty),
    .ts_i          (rd_ent[EW-1 -: TS_W]),
    .src_i         (rd_ent[SRC_W+1 : 2]),
    .ev_i          (rd_ent[1:0]),
    .trace_en_i    (trace_en_i),
    .trace_ready_i (trace_ready_i),
    .pop_o         (pop),
    .state_o       (state_o),
    .trace_valid_o (trace_valid_o),
    .trace_ts_o    (trace_ts_o),
    .trace_src_o   (trace_src_o),
    .trace_old_o   (trace_old_o),
    .trace_ev_o    (trace_ev_o),
    .trace_new_o   (trace_new_o),
    .trace_act_o   (trace_act_o),
    .trace_err_o   (trace_err_o),
    .trace_unexp_o (trace_unexp_o)
  );

  logic unused_full;
  assign unused_full = q_full;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int unsigned TS_W  = 16,
  parameter int unsigned SRC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trace_en_i,
  input logic             trace_ready_i,
  input logic             trace_valid_o,
  input logic [TS_W-1:0]  trace_ts_o,
  input logic [SRC_W-1:0] trace_src_o,
  input logic [1:0]       trace_old_o,
  input logic [1:0]       trace_ev_o,
  input logic [1:0]       trace_new_o,
  input logic [2:0]       trace_act_o,
  input logic [1:0]       trace_err_o,
  input logic             trace_unexp_o,
  input logic [1:0]       state_o,
  input logic             overflow_o
);
  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trace_valid_o && !trace_ready_i) |=> (trace_valid_o && $stable(trace_ts_o)
      && $stable(trace_src_o) && $stable(trace_ev_o) && $stable(trace_new_o)
      && $stable(state_o)));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R10
  gated_record_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trace_valid_o) |-> $past(trace_en_i));

  // R5
  clear_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trace_valid_o && trace_act_o == 3'd5) |-> (trace_new_o == 2'd0 && trace_ev_o == 2'd3));

  // R2
  unexp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trace_valid_o && trace_unexp_o) |-> (trace_old_o == trace_new_o && trace_err_o == 2'd1
      && trace_act_o == 3'd0));

  // R4
  go_from_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trace_valid_o && trace_act_o == 3'd3) |-> (trace_old_o == 2'd1 && trace_ev_o == 2'd1
      && trace_new_o == 2'd2));
endmodule

bind sup_supervisor sup_checker #(.TS_W(TS_W), .SRC_W(SRC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trace_en_i    (trace_en_i),
  .trace_ready_i (trace_ready_i),
  .trace_valid_o (trace_valid_o),
  .trace_ts_o    (trace_ts_o),
  .trace_src_o   (trace_src_o),
  .trace_old_o   (trace_old_o),
  .trace_ev_o    (trace_ev_o),
  .trace_new_o   (trace_new_o),
  .trace_act_o   (trace_act_o),
  .trace_err_o   (trace_err_o),
  .trace_unexp_o (trace_unexp_o),
  .state_o       (state_o),
  .overflow_o    (overflow_o)
);

// File: tb/tb_sup_supervisor.sv
`timescale 1ns/1ps
module tb_sup_supervisor;
  localparam int TS_W = 16;
  localparam int SRC_W = 4;
  localparam int RMAX = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, ev_valid_i, trace_en_i, trace_ready_i;
  logic [1:0] ev_code_i;
  logic [SRC_W-1:0] ev_src_i;
  logic trace_valid_o, trace_unexp_o, overflow_o;
  logic [TS_W-1:0] trace_ts_o;
  logic [SRC_W-1:0] trace_src_o;
  logic [1:0] trace_old_o, trace_ev_o, trace_new_o, trace_err_o, state_o;
  logic [2:0] trace_act_o;

  sup_supervisor #(.TS_W(TS_W), .SRC_W(SRC_W), .DEPTH(8), .RETRY_MAX(RMAX)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ev_valid_i(ev_valid_i), .ev_code_i(ev_code_i),
    .ev_src_i(ev_src_i), .trace_en_i(trace_en_i), .trace_ready_i(trace_ready_i),
    .trace_valid_o(trace_valid_o), .trace_ts_o(trace_ts_o), .trace_src_o(trace_src_o),
    .trace_old_o(trace_old_o), .trace_ev_o(trace_ev_o), .trace_new_o(trace_new_o),
    .trace_act_o(trace_act_o), .trace_err_o(trace_err_o), .trace_unexp_o(trace_unexp_o),
    .state_o(state_o), .overflow_o(overflow_o));

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [SRC_W-1:0] src;
    logic [1:0] old_st, ev, new_st;
    logic [2:0] act;
    logic [1:0] err;
    logic unexp;
  } rec_t;

  rec_t exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  logic [1:0] m_st;
  int m_rl;

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && trace_valid_o && trace_ready_i) begin
      rec_t got, e;
      string t;
      got = '{trace_ts_o, trace_src_o, trace_old_o, trace_ev_o, trace_new_o,
              trace_act_o, trace_err_o, trace_unexp_o};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected record: actual %h expected none", got);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          errors++;
          $display("FAIL %s record: actual %h expected %h", t, got, e);
        end
      end
    end
  end

  task automatic push_ev(input logic [1:0] ev, input logic [SRC_W-1:0] src,
                         input string tag, input bit drop);
    rec_t r;
    r.ts = TS_W'(cyc); r.src = src; r.old_st = m_st; r.ev = ev;
    r.new_st = m_st; r.act = 3'd0; r.err = 2'd0; r.unexp = 1'b0;
    case (m_st)
      2'd0: if (ev == 2'd0) begin r.new_st = 2'd1; r.act = 3'd1; end else r.unexp = 1'b1;
      2'd1: if (ev == 2'd1) begin
              if (m_rl > 0) r.act = 3'd2; else begin r.new_st = 2'd2; r.act = 3'd3; end
            end else if (ev == 2'd2) begin
              r.new_st = 2'd3; r.act = 3'd4; r.err = 2'd2;
            end else r.unexp = 1'b1;
      default: if (ev == 2'd3) begin r.new_st = 2'd0; r.act = 3'd5; end else r.unexp = 1'b1;
    endcase
    if (r.unexp) r.err = 2'd1;
    if (!drop) begin
      if (r.act == 3'd1) m_rl = RMAX;
      else if (r.act == 3'd2) m_rl--;
      m_st = r.new_st;
      if (trace_en_i) begin exp_q.push_back(r); tag_q.push_back(tag); end
    end
    ev_valid_i = 1'b1; ev_code_i = ev; ev_src_i = src;
    @(posedge clk); #1;
    ev_valid_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wait_cyc(3);
    chk(state_o == 2'd0 && !trace_valid_o && !overflow_o, "R1", "in-reset state/valid/ovf",
        {state_o, trace_valid_o, overflow_o}, 0);
    rst_ni = 1'b1;
    m_st = 2'd0; m_rl = 0;
  endtask

  initial begin
    ev_valid_i = 0; ev_code_i = 0; ev_src_i = 0; trace_en_i = 1; trace_ready_i = 1;
    rst_ni = 0;
    do_reset();
    @(negedge clk);
    chk(state_o == 2'd0 && !trace_valid_o && !overflow_o, "R1", "after release",
        {state_o, trace_valid_o, overflow_o}, 0);
    @(posedge clk); #1;

    // R7 latency of the first event
    push_ev(2'd0, 4'h1, "R2", 0);
    @(negedge clk);
    chk(!trace_valid_o && state_o == 2'd0, "R7", "one edge after capture",
        {trace_valid_o, state_o}, 0);
    @(negedge clk);
    chk(trace_valid_o && state_o == 2'd1, "R7", "two edges after capture",
        {trace_valid_o, state_o}, {1'b1, 2'd1});
    @(posedge clk); #1;

    // R3 / R4 / R5 / R6 back-to-back, then gaps
    push_ev(2'd3, 4'h2, "R3", 0);
    push_ev(2'd1, 4'h3, "R4", 0);
    push_ev(2'd1, 4'h4, "R4", 0);
    push_ev(2'd1, 4'h5, "R4", 0);
    wait_cyc(3);
    push_ev(2'd0, 4'h6, "R5", 0);
    push_ev(2'd3, 4'h7, "R5", 0);
    push_ev(2'd2, 4'h8, "R2", 0);
    push_ev(2'd0, 4'h9, "R2", 0);
    push_ev(2'd1, 4'hA, "R4", 0);
    push_ev(2'd1, 4'hB, "R4", 0);
    wait_cyc(2);
    push_ev(2'd2, 4'hC, "R3", 0);
    push_ev(2'd1, 4'hD, "R5", 0);
    push_ev(2'd3, 4'hE, "R6", 0);
    wait_cyc(20);
    chk(exp_q.size() == 0, "R6", "records outstanding", exp_q.size(), 0);
    chk(state_o == 2'd0, "R5", "state after clear", state_o, 0);

    // R10 trace disabled
    trace_en_i = 1'b0;
    push_ev(2'd0, 4'h1, "R10", 0);
    push_ev(2'd2, 4'h2, "R10", 0);
    wait_cyc(10);
    chk(state_o == 2'd3, "R10", "state with trace off", state_o, 3);
    trace_en_i = 1'b1;
    push_ev(2'd3, 4'h3, "R10", 0);
    wait_cyc(10);
    chk(state_o == 2'd0, "R10", "state after re-enable", state_o, 0);

    // R8 / R9 back-pressure and overflow
    trace_ready_i = 1'b0;
    push_ev(2'd0, 4'h0, "R8", 0);
    for (int i = 1; i < 9; i++) push_ev(2'd0, SRC_W'(i), "R9", 0);
    push_ev(2'd1, 4'hF, "R9", 1);
    wait_cyc(5);
    chk(overflow_o == 1'b1, "R9", "overflow flag", overflow_o, 1);
    chk(trace_valid_o && trace_old_o == 2'd0 && trace_new_o == 2'd1 && trace_src_o == 4'h0,
        "R8", "held record", {trace_valid_o, trace_old_o, trace_new_o}, {1'b1, 2'd0, 2'd1});
    chk(state_o == 2'd1, "R8", "state while stalled", state_o, 1);
    trace_ready_i = 1'b1;
    wait_cyc(20);
    chk(exp_q.size() == 0, "R9", "records outstanding", exp_q.size(), 0);
    chk(state_o == 2'd1, "R9", "dropped timeout left ARMED", state_o, 1);
    chk(overflow_o == 1'b1, "R9", "flag still set", overflow_o, 1);

    do_reset();
    @(negedge clk);
    chk(!overflow_o && state_o == 2'd0, "R9", "flag cleared by reset",
        {overflow_o, state_o}, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule